// File: doc/BRIEF.md
# Flash Buffered Program Engine

This block runs the buffered-program sequence of a parallel NOR flash array. The command sequencer raises `start_i` once it has decoded the buffered-program opcode, then routes the following writes to the engine while `active_o` is high. The first routed write carries a word count. The first data write fixes an aligned block of the array, and the engine copies that whole block into an on-chip staging buffer. Each later data write updates the staged copy, provided it falls inside the block.

A final confirm write decides the outcome. On a clean confirm the engine writes the full staged block back to the array, so the words that were not touched keep their old values. Any other confirm value, or an earlier programming error, throws the staged data away. In both cases the engine tells the sequencer to go back to array read. The block models no program timing. Copy-in and write-back take one array access per word, and `busy_o` is high while they run.

Top module: `flash_buf_prog`

## Requirements
- R1: After reset the engine is idle: `active_o`, `busy_o`, `err_o`, `done_o` and `abort_o` are low, `ready_o` is high, and no array access is made.
- R2: After `start_i`, the next write loads the count from the low 8*DEV_BYTES data bits, or from the low 8*BANK_BYTES bits when DEV_BYTES is 0. The default of 8 bits means 0x0102 loads 2. A count of N accepts N+1 data writes, and the write after them is taken as the confirm.
- R3: The first data write, with a nonzero count, captures the block whose base is the write address with its low OFF_W bits cleared (OFF_W = 11, so 2048 words, by default). The capture reads every word of the block once, in ascending address order, with `busy_o` high and `ready_o` low.
- R4: A data write to a word outside the captured block sets `err_o` and does not reach the staged copy.
- R5: A first data write that arrives with the count at zero captures nothing and sets `err_o`. That write also ends the data phase.
- R6: A confirm write whose low byte is 0xD0, with `err_o` low, writes all staged words back in ascending order. Words that received data get the new value and all others keep their old one. `busy_o` stays high during the write-back, and `done_o` pulses as the engine returns to idle.
- R7: A confirm write with any other low byte, or with `err_o` high, makes no array write. It pulses `abort_o` and returns the engine to idle.
- R8: `err_o` stays set until `err_clr_i`. When a new error and `err_clr_i` fall in the same cycle, `err_o` ends up set.
- R9: Writes presented while the engine is idle are ignored: no array access is made, and the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sequencer decoded the buffered-program opcode |
| wr_valid_i | input | 1 | Write routed to the engine this cycle |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 8*BANK_BYTES | Count, data or confirm value |
| err_clr_i | input | 1 | Clears the programming error flag |
| active_o | output | 1 | Engine owns the write path |
| busy_o | output | 1 | Capture or write-back in progress |
| ready_o | output | 1 | Inverse of busy, status ready bit |
| err_o | output | 1 | Sticky programming error |
| done_o | output | 1 | One-cycle pulse when a commit ends |
| abort_o | output | 1 | One-cycle pulse on discard, back to array read |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_rd_o | output | 1 | Array read, data returns next cycle |
| arr_rdata_i | input | 8*BANK_BYTES | Array read data |
| arr_wr_o | output | 1 | Array write strobe |
| arr_wdata_o | output | 8*BANK_BYTES | Array write data |

## Verification
Two pairs of events can fall in the same cycle. The first is the last word of the block copy landing in the staging buffer while the pending first data word targets that same last offset. The bench provokes this by opening a block at its final word. It passes if the committed array holds the new value there and not the copied one. The second pair is a range violation arriving in the same cycle as `err_clr_i`. The bench drives both together, and `err_o` must read high afterwards.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_COUNT, S_DATA, S_CAPT, S_APPLY, S_CONF, S_COMMIT
  } fbp_state_e;

  // log2 of block size in words
  function automatic int blk_word_log2(input int bank_bytes, input int dev_bytes);
    int ndev;
    int byte_log;
    ndev = (dev_bytes != 0) ? bank_bytes / dev_bytes : 1;
    byte_log = ((bank_bytes == 1) ? 8 : 11) + $clog2(ndev);
    return byte_log - $clog2(bank_bytes);
  endfunction
endpackage

// File: rtl/fbp_stage_buf.sv
module fbp_stage_buf #(
  parameter int OFF_W  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << OFF_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fbp_range_chk.sv
module fbp_range_chk #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 11
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-OFF_W-1:0] base_tag_i,
  output logic                    in_blk_o,
  output logic [OFF_W-1:0]        off_o
);
  // aligned base: a word lies inside iff its upper bits match the tag
  assign in_blk_o = (addr_i[ADDR_W-1:OFF_W] == base_tag_i);
  assign off_o    = addr_i[OFF_W-1:0];
endmodule

// File: rtl/flash_buf_prog.sv
module flash_buf_prog
  import fbp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BANK_BYTES = 2,
  parameter int DEV_BYTES  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    wr_valid_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [8*BANK_BYTES-1:0] wr_data_i,
  input  logic                    err_clr_i,
  output logic                    active_o,
  output logic                    busy_o,
  output logic                    ready_o,
  output logic                    err_o,
  output logic                    done_o,
  output logic                    abort_o,
  output logic [ADDR_W-1:0]       arr_addr_o,
  output logic                    arr_rd_o,
  input  logic [8*BANK_BYTES-1:0] arr_rdata_i,
  output logic                    arr_wr_o,
  output logic [8*BANK_BYTES-1:0] arr_wdata_o
);
  localparam int DATA_W = 8 * BANK_BYTES;
  localparam int CNT_W  = 8 * ((DEV_BYTES != 0) ? DEV_BYTES : BANK_BYTES);
  localparam int OFF_W  = blk_word_log2(BANK_BYTES, DEV_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam logic [OFF_W:0] PTR_END  = (OFF_W+1)'(WORDS);
  localparam logic [OFF_W:0] PTR_LAST = (OFF_W+1)'(WORDS - 1);

  fbp_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [TAG_W-1:0]    tag_q;
  logic                valid_q, err_q, done_q, abort_q;
  logic [OFF_W:0]      ptr_q;
  logic                cap_vld_q;
  logic [OFF_W-1:0]    cap_idx_q, pend_off_q;
  logic [DATA_W-1:0]   pend_data_q;

  logic                in_blk;
  logic [OFF_W-1:0]    wr_off;
  logic                buf_we;
  logic [OFF_W-1:0]    buf_waddr;
  logic [DATA_W-1:0]   buf_wdata, buf_rdata;
  logic                data_wr, err_set;

  fbp_range_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rng (
    .addr_i(wr_addr_i), .base_tag_i(tag_q), .in_blk_o(in_blk), .off_o(wr_off)
  );

  fbp_stage_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .we_i(buf_we), .waddr_i(buf_waddr), .wdata_i(buf_wdata),
    .raddr_i(ptr_q[OFF_W-1:0]), .rdata_o(buf_rdata)
  );

  assign data_wr = (state_q == S_DATA) && wr_valid_i;
  assign err_set = data_wr && (valid_q ? !in_blk : (cnt_q == '0));

  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = wr_off;
    buf_wdata = wr_data_i;
    if (cap_vld_q) begin
      buf_we    = 1'b1;
      buf_waddr = cap_idx_q;
      buf_wdata = arr_rdata_i;
    end else if (state_q == S_APPLY) begin
      buf_we    = 1'b1;
      buf_waddr = pend_off_q;
      buf_wdata = pend_data_q;
    end else if (data_wr && valid_q && in_blk) begin
      buf_we    = 1'b1;
    end
  end

  assign arr_rd_o    = (state_q == S_CAPT) && (ptr_q != PTR_END);
  assign arr_wr_o    = (state_q == S_COMMIT);
  assign arr_addr_o  = {tag_q, ptr_q[OFF_W-1:0]};
  assign arr_wdata_o = buf_rdata;

  assign busy_o   = (state_q == S_CAPT) || (state_q == S_APPLY) || (state_q == S_COMMIT);
  assign ready_o  = !busy_o;
  assign active_o = (state_q != S_IDLE);
  assign err_o    = err_q;
  assign done_o   = done_q;
  assign abort_o  = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      tag_q       <= '0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
      ptr_q       <= '0;
      cap_vld_q   <= 1'b0;
      cap_idx_q   <= '0;
      pend_off_q  <= '0;
      pend_data_q <= '0;
    end else begin
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      cap_vld_q <= arr_rd_o;
      cap_idx_q <= ptr_q[OFF_W-1:0];
      if (err_set)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) state_q <= S_COUNT;
        S_COUNT: if (wr_valid_i) begin
          cnt_q   <= wr_data_i[CNT_W-1:0];
          state_q <= S_DATA;
        end
        S_DATA: if (wr_valid_i) begin
          if (!valid_q && cnt_q != '0) begin
            tag_q       <= wr_addr_i[ADDR_W-1:OFF_W];
            pend_off_q  <= wr_off;
            pend_data_q <= wr_data_i;
            ptr_q       <= '0;
            state_q     <= S_CAPT;
          end else if (cnt_q == '0) begin
            state_q <= S_CONF;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        S_CAPT: begin
          if (ptr_q == PTR_END) state_q <= S_APPLY;
          else                  ptr_q   <= ptr_q + 1'b1;
        end
        S_APPLY: begin
          valid_q <= 1'b1;
          cnt_q   <= cnt_q - CNT_W'(1);
          state_q <= S_DATA;
        end
        S_CONF: if (wr_valid_i) begin
          if (wr_data_i[7:0] == 8'hD0 && !err_q) begin
            ptr_q   <= '0;
            state_q <= S_COMMIT;
          end else begin
            valid_q <= 1'b0;
            abort_q <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_COMMIT: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == PTR_LAST) begin
            valid_q <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4
  range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && valid_q && !in_blk) |=> err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  // R3
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |-> (busy_o && !ready_o && !arr_wr_o));

  // R6
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_o |-> (busy_o && !arr_rd_o));

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!active_o && !abort_o));

  // R7
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!active_o && !busy_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o) |-> (!arr_rd_o && !arr_wr_o));

  // R2
  last_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && valid_q && cnt_q == '0) |=> (state_q == S_CONF));
endmodule

// File: tb/flash_buf_prog_test.sv
module flash_buf_prog_test;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, wr_valid, err_clr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic active, busy, ready, err, done, abort;
  logic [AW-1:0] arr_addr;
  logic arr_rd, arr_wr;
  logic [DW-1:0] arr_rdata, arr_wdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_buf_prog uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_valid_i(wr_valid),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .err_clr_i(err_clr),
    .active_o(active), .busy_o(busy), .ready_o(ready), .err_o(err),
    .done_o(done), .abort_o(abort), .arr_addr_o(arr_addr), .arr_rd_o(arr_rd),
    .arr_rdata_i(arr_rdata), .arr_wr_o(arr_wr), .arr_wdata_o(arr_wdata)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 7) ^ 16'hA5A5;
  endfunction

  // array model and access monitors
  logic [DW-1:0] mem [NW];
  int rd_cnt = 0, wr_cnt = 0, rd_seq_bad = 0, wr_seq_bad = 0;
  logic [AW-1:0] rd_first, wr_first, last_rd, last_wr;
  logic prev_rd = 1'b0, prev_wr = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= pat(i);
    end else begin
      if (arr_rd) begin
        arr_rdata <= mem[arr_addr];
        rd_cnt <= rd_cnt + 1;
        if (!prev_rd) rd_first <= arr_addr;
        else if (arr_addr != last_rd + 1'b1) rd_seq_bad <= rd_seq_bad + 1;
        last_rd <= arr_addr;
      end
      if (arr_wr) begin
        mem[arr_addr] <= arr_wdata;
        wr_cnt <= wr_cnt + 1;
        if (!prev_wr) wr_first <= arr_addr;
        else if (arr_addr != last_wr + 1'b1) wr_seq_bad <= wr_seq_bad + 1;
        last_wr <= arr_addr;
      end
      prev_rd <= arr_rd;
      prev_wr <= arr_wr;
    end
  end

  bit seen_done, seen_abort, seen_busy;
  int rd0, wr0, rbad0, wbad0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (done)  seen_done  = 1'b1;
    if (abort) seen_abort = 1'b1;
    if (busy)  seen_busy  = 1'b1;
  endtask

  task automatic mark();
    seen_done = 0; seen_abort = 0; seen_busy = 0;
    rd0 = rd_cnt; wr0 = wr_cnt; rbad0 = rd_seq_bad; wbad0 = wr_seq_bad;
  endtask

  task automatic wait_free();
    for (int i = 0; i < 6000 && busy; i++) step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit clr = 0);
    wait_free();
    wr_valid = 1'b1; wr_addr = a; wr_data = d; err_clr = clr;
    step();
    wr_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic begin_seq(input logic [DW-1:0] count);
    start = 1'b1;
    step();
    start = 1'b0;
    wr('0, count);
  endtask

  task automatic finish_seq();
    for (int i = 0; i < 6000 && active; i++) step();
  endtask

  task automatic t_reset();
    check(!active && !busy && ready && !err && !done && !abort, "R1",
          {26'd0, active, busy, ready, err, done, abort}, 32'h8);
    check(rd_cnt == 0 && wr_cnt == 0, "R1", rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_idle_ignore();
    mark();
    wr(13'h0010, 16'h1234);
    wr(13'h0011, 16'h00D0);
    step();
    check(!active && rd_cnt == rd0 && wr_cnt == wr0, "R9", rd_cnt - rd0 + wr_cnt - wr0, 0);
    check(mem[16] == pat(16), "R9", mem[16], pat(16));
  endtask

  task automatic t_program();
    mark();
    begin_seq(16'h0102);            // masked to 2 -> three data words
    wr(13'h0805, 16'h1111);
    wait_free();
    check(seen_busy && rd_cnt - rd0 == 2048, "R3", rd_cnt - rd0, 2048);
    check(rd_first == 13'h0800 && rd_seq_bad == rbad0, "R3", rd_first, 13'h0800);
    wr(13'h0806, 16'h2222);
    wr(13'h0807, 16'h3333);
    check(active && !err, "R2", {active, err}, 2'b10);
    mark();
    wr('0, 16'h00D0);
    finish_seq();
    check(seen_done && seen_busy && !seen_abort, "R2", {seen_done, seen_abort}, 2'b10);
    check(wr_cnt - wr0 == 2048 && wr_first == 13'h0800 && wr_seq_bad == wbad0, "R6",
          wr_cnt - wr0, 2048);
    check(mem[13'h0805] == 16'h1111 && mem[13'h0806] == 16'h2222 && mem[13'h0807] == 16'h3333,
          "R6", mem[13'h0806], 16'h2222);
    check(mem[13'h0804] == pat('h804) && mem[13'h0808] == pat('h808)
          && mem[13'h0FFF] == pat('hFFF), "R6", mem[13'h0808], pat('h808));
    check(mem[13'h07FF] == pat('h7FF) && mem[13'h1000] == pat('h1000), "R6",
          mem[13'h1000], pat('h1000));
  endtask

  task automatic t_edge();
    mark();
    begin_seq(16'h0001);
    wr(13'h1FFF, 16'hBEEF);         // last offset: collides with final capture word
    wr(13'h1800, 16'hCAFE);
    wr('0, 16'h00D0);
    finish_seq();
    check(seen_done, "R6", seen_done, 1);
    check(mem[13'h1FFF] == 16'hBEEF, "R3", mem[13'h1FFF], 16'hBEEF);
    check(mem[13'h1800] == 16'hCAFE && mem[13'h1801] == pat('h1801), "R6",
          mem[13'h1800], 16'hCAFE);
  endtask

  task automatic t_range();
    mark();
    begin_seq(16'h0002);
    wr(13'h0410, 16'h4444);
    wr(13'h0900, 16'h5555, 1'b1);   // out of block with clear in same cycle
    check(err, "R8", err, 1);
    check(err, "R4", err, 1);
    wr(13'h0411, 16'h6666);
    check(err, "R8", err, 1);
    mark();
    wr('0, 16'h00D0);
    finish_seq();
    check(seen_abort && !seen_done && wr_cnt == wr0, "R7", wr_cnt - wr0, 0);
    check(mem[13'h0410] == pat('h410) && mem[13'h0900] == pat('h900), "R4",
          mem[13'h0410], pat('h410));
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    check(!err, "R8", err, 0);
  endtask

  task automatic t_badconf();
    mark();
    begin_seq(16'h0001);
    wr(13'h0020, 16'h7777);
    wr(13'h0021, 16'h8888);
    mark();
    wr('0, 16'h00FF);
    finish_seq();
    check(seen_abort && wr_cnt == wr0 && !err, "R7", wr_cnt - wr0, 0);
    check(mem[13'h0020] == pat('h20) && mem[13'h0021] == pat('h21), "R7",
          mem[13'h0020], pat('h20));
  endtask

  task automatic t_zero();
    mark();
    begin_seq(16'h0000);
    wr(13'h0030, 16'h9999);
    check(err && rd_cnt == rd0, "R5", rd_cnt - rd0, 0);
    check(active && !busy, "R5", {active, busy}, 2'b10);
    wr('0, 16'h00D0);
    finish_seq();
    check(seen_abort && wr_cnt == wr0 && mem[13'h0030] == pat('h30), "R5",
          mem[13'h0030], pat('h30));
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    start = 0; wr_valid = 0; err_clr = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_idle_ignore();
    t_program();
    t_edge();
    t_range();
    t_badconf();
    t_zero();
    summary();
  end
endmodule